// File: doc/BRIEF.md
# Atomic load-and-clear word unit

This unit carries out the semaphore primitive of a processor's load/store pipe. One memory word is read and zero is written back to the same location, and the memory lock is held across both accesses so that no other requester can come between them. The word that was read goes back to the destination register. The pipe passes in the raw instruction word together with the values of the base and index registers. The unit forms the address from these, checks alignment, runs the locked read and write, and then issues the register writebacks.

Two addressing forms are supported. The displacement form adds a 5-bit signed displacement to the base and can update the base before or after the access. The indexed form adds an index register, optionally scaled by four, and can update the base after the access. The target word must sit on a 16-byte boundary. A misaligned target raises a fault, and in that case the unit touches neither memory nor any register.

The control is a five-state machine. IDLE goes to READ on an accepted operation with an aligned address, or to FAULT if the address is misaligned. READ goes to WRITE when the read is acknowledged. WRITE goes to DONE when the zero write is acknowledged. DONE and FAULT both return to IDLE after one cycle.

Top module: `ldclr_unit`

## Requirements
- R1: After reset the unit is idle. busy, fault, mem_req, mem_lock, rt_we and rb_we are all low.
- R2: When instruction bit 12 is 1, bits [20:16] hold a displacement whose sign is bit 16 and whose magnitude bits are [20:17], so the value is -16 + [20:17] when bit 16 is 1 and [20:17] otherwise. With bit 5 clear, the word is accessed at base + displacement and the base is not updated.
- R3: When bit 12 is 1 and bit 5 is 1, the base is replaced by base + displacement. If bit 13 is 1 (pre-modify), the access is at base + displacement. If bit 13 is 0 (post-modify), the access is at the unmodified base.
- R4: When bit 12 is 0, the offset is the index value, shifted left by 2 when bit 13 is 1. With bit 5 clear, the access is at base + offset and there is no update. With bit 5 set, the access is at the base and the base is replaced by base + offset.
- R5: The unit reads the target word with mem_lock high, then writes zero to the same address. mem_lock stays high continuously from the read into the write. The value read is returned on rt_data.
- R6: If the low 4 bits of the access address are not zero, fault pulses for one cycle, one clock edge after acceptance. No memory request is made and no register is written.
- R7: When a base update is due and rb equals rt, only rt is written, and it receives the loaded value. rb_we stays low.
- R8: busy is high from the edge that accepts an operation until the writeback or fault cycle ends. An op_valid seen while busy is high is ignored.
- R9: A memory request holds its address and direction until it is acknowledged. The writeback occurs 3 + 2L clock edges after acceptance, where L is the number of wait cycles per access.
- R10: The destination register number is instruction bits [4:0], and the base register number is bits [25:21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_insn | input | 32 | Instruction word |
| op_base | input | XLEN | Base register value |
| op_index | input | XLEN | Index register value |
| busy | output | 1 | Operation in flight |
| fault | output | 1 | Alignment fault pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Exclusive-access hold |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Write data (always zero) |
| mem_rdata | input | XLEN | Read data, valid with ack |
| mem_ack | input | 1 | Request completed this cycle |
| rt_we | output | 1 | Destination write enable |
| rt_idx | output | 5 | Destination register number |
| rt_data | output | XLEN | Old memory word |
| rb_we | output | 1 | Base update enable |
| rb_idx | output | 5 | Base register number |
| rb_data | output | XLEN | Updated base value |

## Verification
With a zero-wait memory, the writeback is due on the third clock edge after the edge that accepts the operation. Each wait cycle adds one edge per access, so a latency of L gives 3 + 2L edges. A fault pulse is due on the first edge after acceptance. The bench stamps the accepting edge and the edge on which it sees rt_we or fault with one cycle counter sampled at the rising edge, and compares the difference against these figures. It drives inputs and reads its result registers only at falling edges.

// File: rtl/lcw_pkg.sv
`timescale 1ns/1ps
package lcw_pkg;
    localparam int REG_W  = 5;
    localparam int INSN_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } lcw_state_e;

    typedef enum logic [1:0] {
        MOD_NONE,
        MOD_PRE,
        MOD_POST
    } lcw_mod_e;
endpackage

// File: rtl/lcw_decode.sv
`timescale 1ns/1ps
module lcw_decode
    import lcw_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int ALIGN_LG  = 4,
    parameter int IDX_SHIFT = 2
) (
    input  logic [4:0]      fld,
    input  logic            form_disp,
    input  logic            sel_au,
    input  logic            sel_m,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] index,
    output logic [XLEN-1:0] acc_addr,
    output logic [XLEN-1:0] new_base,
    output logic            upd_en,
    output logic            misal
);
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] eff;
    lcw_mod_e        mode;

    // sign sits in the lowest field bit
    assign disp = {{(XLEN-4){fld[0]}}, fld[4:1]};

    generate
        if (IDX_SHIFT > 0) begin : g_scale
            assign scaled = {index[XLEN-1-IDX_SHIFT:0], {IDX_SHIFT{1'b0}}};
        end else begin : g_noscale
            assign scaled = index;
        end
    endgenerate

    always_comb begin
        if (form_disp) begin
            offset = disp;
            if (sel_m) mode = sel_au ? MOD_PRE : MOD_POST;
            else       mode = MOD_NONE;
        end else begin
            offset = sel_au ? scaled : index;
            mode   = sel_m ? MOD_POST : MOD_NONE;
        end
    end

    assign eff      = base + offset;
    assign acc_addr = (mode == MOD_POST) ? base : eff;
    assign new_base = eff;
    assign upd_en   = (mode != MOD_NONE);
    assign misal    = |acc_addr[ALIGN_LG-1:0];
endmodule

// File: rtl/lcw_seq.sv
`timescale 1ns/1ps
module lcw_seq
    import lcw_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int ALIGN_LG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            misal,
    input  logic [XLEN-1:0] acc_addr,
    input  logic            mem_ack,
    output logic            busy,
    output logic            fault,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_lock,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            done,
    output logic            rd_capture
);
    lcw_state_e      state_q, state_d;
    logic [XLEN-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            addr_q <= '0;
        else if (state_q == ST_IDLE && start)  addr_q <= acc_addr;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = misal ? ST_FAULT : ST_READ;
            ST_READ:  if (mem_ack) state_d = ST_WRITE;
            ST_WRITE: if (mem_ack) state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            ST_FAULT:              state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b1;
        fault      = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_lock   = 1'b0;
        done       = 1'b0;
        rd_capture = 1'b0;
        mem_addr   = addr_q;
        mem_wdata  = '0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_READ: begin
                mem_req    = 1'b1;
                mem_lock   = 1'b1;
                rd_capture = mem_ack;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_lock = 1'b1;
            end
            ST_DONE:  done  = 1'b1;
            ST_FAULT: fault = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    a_r5_lock_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);
    a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == '0));
    a_r5_lock_into_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_lock && $stable(mem_addr)));
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    a_r6_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ALIGN_LG-1:0] == '0));
    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && !done));
endmodule

// File: rtl/lcw_wb.sv
`timescale 1ns/1ps
module lcw_wb
    import lcw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [REG_W-1:0] rt_in,
    input  logic [REG_W-1:0] rb_in,
    input  logic             upd_in,
    input  logic [XLEN-1:0]  nb_in,
    input  logic             capture,
    input  logic [XLEN-1:0]  rdata,
    input  logic             done,
    output logic             rt_we,
    output logic [REG_W-1:0] rt_idx,
    output logic [XLEN-1:0]  rt_data,
    output logic             rb_we,
    output logic [REG_W-1:0] rb_idx,
    output logic [XLEN-1:0]  rb_data
);
    logic [REG_W-1:0] rt_q, rb_q;
    logic             upd_q;
    logic [XLEN-1:0]  nb_q, old_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q  <= '0;
            rb_q  <= '0;
            upd_q <= 1'b0;
            nb_q  <= '0;
        end else if (accept) begin
            rt_q  <= rt_in;
            rb_q  <= rb_in;
            upd_q <= upd_in;
            nb_q  <= nb_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       old_q <= '0;
        else if (capture) old_q <= rdata;
    end

    // loaded value wins when destination and base coincide
    assign rt_we   = done;
    assign rt_idx  = rt_q;
    assign rt_data = old_q;
    assign rb_we   = done && upd_q && (rb_q != rt_q);
    assign rb_idx  = rb_q;
    assign rb_data = nb_q;

    a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |-> (rt_we && (rb_idx != rt_idx)));
endmodule

// File: rtl/ldclr_unit.sv
`timescale 1ns/1ps
module ldclr_unit
    import lcw_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int ALIGN_LG  = 4,
    parameter int IDX_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [INSN_W-1:0] op_insn,
    input  logic [XLEN-1:0]   op_base,
    input  logic [XLEN-1:0]   op_index,
    output logic              busy,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ack,
    output logic              rt_we,
    output logic [REG_W-1:0]  rt_idx,
    output logic [XLEN-1:0]   rt_data,
    output logic              rb_we,
    output logic [REG_W-1:0]  rb_idx,
    output logic [XLEN-1:0]   rb_data
);
    logic [XLEN-1:0] acc_addr, new_base;
    logic            upd_en, misal, accept, done, rd_capture;
    logic            unused_insn_bits;

    assign unused_insn_bits = ^{op_insn[31:26], op_insn[15:14], op_insn[11:6]};
    assign accept = op_valid && !busy;

    lcw_decode #(.XLEN(XLEN), .ALIGN_LG(ALIGN_LG), .IDX_SHIFT(IDX_SHIFT)) u_dec (
        .fld       (op_insn[20:16]),
        .form_disp (op_insn[12]),
        .sel_au    (op_insn[13]),
        .sel_m     (op_insn[5]),
        .base      (op_base),
        .index     (op_index),
        .acc_addr  (acc_addr),
        .new_base  (new_base),
        .upd_en    (upd_en),
        .misal     (misal)
    );

    lcw_seq #(.XLEN(XLEN), .ALIGN_LG(ALIGN_LG)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (op_valid),
        .misal      (misal),
        .acc_addr   (acc_addr),
        .mem_ack    (mem_ack),
        .busy       (busy),
        .fault      (fault),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_lock   (mem_lock),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .done       (done),
        .rd_capture (rd_capture)
    );

    lcw_wb #(.XLEN(XLEN)) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .rt_in   (op_insn[4:0]),
        .rb_in   (op_insn[25:21]),
        .upd_in  (upd_en),
        .nb_in   (new_base),
        .capture (rd_capture),
        .rdata   (mem_rdata),
        .done    (done),
        .rt_we   (rt_we),
        .rt_idx  (rt_idx),
        .rt_data (rt_data),
        .rb_we   (rb_we),
        .rb_idx  (rb_idx),
        .rb_data (rb_data)
    );

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r6_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!fault && !busy));
    a_r8_wb_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> busy);
endmodule

// File: tb/sim_ldclr_unit.sv
`timescale 1ns/1ps
module sim_ldclr_unit;
    typedef struct packed {
        logic [4:0]  rb;
        logic [4:0]  rt;
        logic [4:0]  fld;
        logic        fi;
        logic        fau;
        logic        fm;
        logic [31:0] base;
        logic [31:0] idx;
        logic [31:0] addr;
        logic        upd;
        logic [31:0] nbase;
        logic        flt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{5'd4,  5'd3,  5'b00000, 1'b1, 1'b0, 1'b0, 32'h100, 32'h0,  32'h100, 1'b0, 32'h0,   1'b0},
        '{5'd5,  5'd6,  5'b00001, 1'b1, 1'b1, 1'b1, 32'h200, 32'h0,  32'h1F0, 1'b1, 32'h1F0, 1'b0},
        '{5'd7,  5'd8,  5'b00001, 1'b1, 1'b0, 1'b1, 32'h300, 32'h0,  32'h300, 1'b1, 32'h2F0, 1'b0},
        '{5'd9,  5'd10, 5'b00000, 1'b0, 1'b0, 1'b0, 32'h400, 32'h30, 32'h430, 1'b0, 32'h0,   1'b0},
        '{5'd11, 5'd12, 5'b00000, 1'b0, 1'b1, 1'b0, 32'h400, 32'h8,  32'h420, 1'b0, 32'h0,   1'b0},
        '{5'd13, 5'd14, 5'b00000, 1'b0, 1'b1, 1'b1, 32'h500, 32'hC,  32'h500, 1'b1, 32'h530, 1'b0},
        '{5'd15, 5'd16, 5'b00000, 1'b0, 1'b0, 1'b1, 32'h600, 32'h40, 32'h600, 1'b1, 32'h640, 1'b0},
        '{5'd17, 5'd18, 5'b00110, 1'b1, 1'b0, 1'b0, 32'h700, 32'h0,  32'h703, 1'b0, 32'h0,   1'b1},
        '{5'd19, 5'd20, 5'b00000, 1'b1, 1'b0, 1'b1, 32'h708, 32'h0,  32'h708, 1'b0, 32'h0,   1'b1},
        '{5'd21, 5'd22, 5'b11110, 1'b1, 1'b1, 1'b1, 32'h801, 32'h0,  32'h810, 1'b1, 32'h810, 1'b0},
        '{5'd23, 5'd24, 5'b11110, 1'b1, 1'b0, 1'b0, 32'h8F1, 32'h0,  32'h900, 1'b0, 32'h0,   1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_insn = '0, op_base = '0, op_index = '0;
    logic        busy, fault, mem_req, mem_we, mem_lock, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rt_data, rb_data;
    logic        rt_we, rb_we;
    logic [4:0]  rt_idx, rb_idx;

    logic [31:0] mem [0:255];
    int lat = 0, wcnt = 0;
    int n_chk = 0, n_err = 0;
    int cyc = 0, acc_cyc = 0, wb_cyc = 0, flt_cyc = 0;
    int wb_n = 0, flt_n = 0, rd_n = 0, wr_n = 0, lock_err = 0, busy_gap = 0;
    logic [31:0] rd_addr = '0, wr_addr = '0, got_rt_data = '0, got_rb_data = '0;
    logic [4:0]  got_rt_idx = '0, got_rb_idx = '0;
    logic        got_rb_we = 1'b0;

    always #2.5 clk = ~clk;

    ldclr_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_insn(op_insn),
        .op_base(op_base), .op_index(op_index), .busy(busy), .fault(fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data),
        .rb_we(rb_we), .rb_idx(rb_idx), .rb_data(rb_data)
    );

    assign mem_ack   = mem_req && (wcnt == lat);
    assign mem_rdata = mem[mem_addr[11:4]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mem[k] <= 32'hC0DE_0000 + k;
            wcnt <= 0;
        end else begin
            if (mem_req && !mem_ack) wcnt <= wcnt + 1;
            else                     wcnt <= 0;
            if (mem_req && mem_ack && mem_we) mem[mem_addr[11:4]] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (op_valid && !busy) acc_cyc = cyc;
            if (rt_we) begin
                wb_n++; wb_cyc = cyc;
                got_rt_idx = rt_idx; got_rt_data = rt_data;
                got_rb_we = rb_we; got_rb_idx = rb_idx; got_rb_data = rb_data;
                if (!busy) busy_gap++;
            end
            if (fault) begin flt_n++; flt_cyc = cyc; end
            if (mem_req && mem_ack && !mem_we) begin rd_n++; rd_addr = mem_addr; end
            if (mem_req && mem_ack && mem_we)  begin wr_n++; wr_addr = mem_addr; end
            if (mem_req && !mem_lock) lock_err++;
        end
        cyc++;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL [%s] %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rb, input logic [4:0] rt,
                                       input logic [4:0] fld, input logic fi,
                                       input logic fau, input logic fm);
        return {6'b000011, rb, fld, 2'b00, fau, fi, 6'b000111, fm, rt};
    endfunction

    task automatic issue(input logic [31:0] insn, input logic [31:0] b, input logic [31:0] x);
        @(negedge clk);
        op_valid = 1'b1; op_insn = insn; op_base = b; op_index = x;
        @(negedge clk);
        op_valid = 1'b0;
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL [watchdog] run hung: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int b_wb, b_flt, b_rd, b_wr;
        logic [31:0] exp_old, exp_other;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(!busy && !fault, "R1", "busy/fault after reset", {busy, fault}, 0);
        chk(!mem_req && !mem_lock, "R1", "memory idle after reset", {mem_req, mem_lock}, 0);
        chk(!rt_we && !rb_we, "R1", "no writeback after reset", {rt_we, rb_we}, 0);

        for (int v = 0; v < NV; v++) begin
            tag = VECS[v].fi ? (VECS[v].fm ? "R3" : "R2") : "R4";
            b_wb = wb_n; b_flt = flt_n; b_rd = rd_n; b_wr = wr_n;
            exp_old = mem[VECS[v].addr[11:4]];
            issue(mk(VECS[v].rb, VECS[v].rt, VECS[v].fld, VECS[v].fi, VECS[v].fau, VECS[v].fm),
                  VECS[v].base, VECS[v].idx);
            if (VECS[v].flt) begin
                chk(flt_n == b_flt + 1, "R6", "fault pulses", flt_n - b_flt, 1);
                chk(flt_cyc - acc_cyc == 1, "R6", "fault timing", flt_cyc - acc_cyc, 1);
                chk(rd_n == b_rd && wr_n == b_wr, "R6", "no memory access", rd_n + wr_n, b_rd + b_wr);
                chk(wb_n == b_wb, "R6", "no writeback", wb_n, b_wb);
                chk(mem[VECS[v].addr[11:4]] == exp_old, "R6", "memory intact",
                    mem[VECS[v].addr[11:4]], exp_old);
            end else begin
                chk(wb_n == b_wb + 1 && flt_n == b_flt, "R5", "one writeback", wb_n - b_wb, 1);
                chk(rd_addr == VECS[v].addr, tag, "read address", rd_addr, VECS[v].addr);
                chk(wr_addr == VECS[v].addr, "R5", "write address", wr_addr, VECS[v].addr);
                chk(got_rt_data == exp_old, "R5", "old value returned", got_rt_data, exp_old);
                chk(mem[VECS[v].addr[11:4]] == 32'h0, "R5", "word cleared",
                    mem[VECS[v].addr[11:4]], 0);
                chk(wb_cyc - acc_cyc == 3, "R9", "zero-wait latency", wb_cyc - acc_cyc, 3);
                chk(got_rt_idx == VECS[v].rt, "R10", "rt number", got_rt_idx, VECS[v].rt);
                chk(got_rb_we == VECS[v].upd, tag, "base update enable", got_rb_we, VECS[v].upd);
                if (VECS[v].upd) begin
                    chk(got_rb_idx == VECS[v].rb, "R10", "rb number", got_rb_idx, VECS[v].rb);
                    chk(got_rb_data == VECS[v].nbase, tag, "new base", got_rb_data, VECS[v].nbase);
                end
            end
        end

        // R7: destination equals base under pre-modify
        exp_old = mem[8'h9F];
        b_wb = wb_n;
        issue(mk(5'd5, 5'd5, 5'b00001, 1'b1, 1'b1, 1'b1), 32'hA00, 32'h0);
        chk(wb_n == b_wb + 1, "R7", "writeback occurred", wb_n - b_wb, 1);
        chk(!got_rb_we, "R7", "base write suppressed", got_rb_we, 0);
        chk(got_rt_idx == 5'd5 && got_rt_data == exp_old, "R7", "loaded value kept",
            got_rt_data, exp_old);

        // R9: waited memory, latency 3 + 2*2
        lat = 2;
        exp_old = mem[8'hB0];
        issue(mk(5'd1, 5'd2, 5'b00000, 1'b1, 1'b0, 1'b0), 32'hB00, 32'h0);
        chk(wb_cyc - acc_cyc == 7, "R9", "waited latency", wb_cyc - acc_cyc, 7);
        chk(got_rt_data == exp_old, "R9", "waited data", got_rt_data, exp_old);
        chk(lock_err == 0, "R5", "lock with every request", lock_err, 0);

        // R8: op offered while busy is ignored
        lat = 3;
        b_wb = wb_n; b_rd = rd_n;
        exp_other = mem[8'hD0];
        @(negedge clk);
        op_valid = 1'b1; op_insn = mk(5'd1, 5'd2, 5'b00000, 1'b1, 1'b0, 1'b0);
        op_base = 32'hC00; op_index = 32'h0;
        @(negedge clk);
        chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
        op_base = 32'hD00; op_insn = mk(5'd3, 5'd4, 5'b00000, 1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        op_valid = 1'b0;
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(wb_n == b_wb + 1, "R8", "single writeback", wb_n - b_wb, 1);
        chk(rd_n == b_rd + 1, "R8", "single read", rd_n - b_rd, 1);
        chk(mem[8'hD0] == exp_other, "R8", "ignored target intact", mem[8'hD0], exp_other);
        chk(got_rt_idx == 5'd2, "R8", "first op retired", got_rt_idx, 2);
        chk(busy_gap == 0, "R8", "busy through writeback", busy_gap, 0);

        // R8: accepted again once idle
        lat = 0;
        b_wb = wb_n;
        issue(mk(5'd3, 5'd4, 5'b00000, 1'b1, 1'b0, 1'b0), 32'hD00, 32'h0);
        chk(wb_n == b_wb + 1 && got_rt_data == exp_other, "R8", "accepted when idle",
            got_rt_data, exp_other);
        chk(lock_err == 0, "R5", "lock held overall", lock_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule